// File: doc/BRIEF.md
# Prime-Field Modular Arithmetic Coprocessor

This block is a slave accelerator for arithmetic modulo a prime. A single host processor drives it through a word-wide register bus, and no arbitration is needed. The host writes three wide operands as 32-bit words: the two inputs `x` and `y` and the modulus `m`. It then starts one operation by writing a one-hot code to the control register. The block holds exactly one operation at a time. Each code enables exactly one of the arithmetic units: modular addition, modular subtraction, or a shift-and-add modular multiplier. The division code is accepted but has no unit behind it. It completes at once, raises an error flag and leaves a zero result.

The host polls the status register until the done flag appears. The result `z` stays hidden until the host writes the active code with the read bit set. The host then reads the result words and writes the clear code, which returns the block to idle. Reads return data one cycle after the read strobe.

Top module: `modarith_cop`

## Requirements
- R1: After reset, the status register, every operand word and every result word read as zero.
- R2: Word addresses 8..12, 16..20 and 24..28 hold `x`, `y` and `m`, least significant word at the lowest address. They read back what was written. Writes to the unused index addresses 13..15, 21..23 and 29..31 change nothing. The read data appears the cycle after the read strobe.
- R3: A write to the control register (address 0) starts an operation only when it holds exactly one of the codes 1 = multiply, 2 = subtract, 4 = add, 8 = divide and every other bit is zero. Any other value written while idle is ignored, and the status stays zero.
- R4: The add code yields (x + y) mod m, computed with one subtraction of m when the sum is at least m. The inputs are below m.
- R5: The subtract code yields (x − y) mod m, computed with one addition of m when the difference is negative.
- R6: The multiply code yields (x · y) mod m using an interleaved shift-and-add loop of one iteration per multiplier bit.
- R7: The status register (address 1) holds bit 0 = done, bit 1 = busy and bit 2 = error. While an operation runs, busy is set and every control write is ignored.
- R8: The result words at addresses 32..36 read zero until the control register receives the active code ORed with the read bit 0x10. Any other control value written while done leaves them hidden.
- R9: Writing the clear code 0x20 while done, or after the read bit was accepted, returns the block to idle. Status and result then read zero.
- R10: The divide code sets done and error together on the next cycle. Its result reads zero even after the read bit is accepted, and the clear code drops both flags.
- R11: Operand writes are ignored unless the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, data returned on the next cycle |
| bus_addr | input | ADDR_W (6) | Word address: region in the upper bits, word index in the lower bits |
| bus_wdata | input | WORD_W (32) | Write data |
| bus_rdata | output | WORD_W (32) | Registered read data |

## Verification
The assertions take several things for granted about the inputs. Read and write strobes are never both high. The modulus is nonzero, and both operands are already below it. Multiplication and the single-step corrections are only correct under those conditions. The stimulus draws a random modulus with its top bit and lowest bit set, then reduces random operands modulo that modulus. The directed cases use small moduli with operands at zero and at m − 1, so every vector stays inside those conditions.

// File: rtl/modarith_pkg.sv
package modarith_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE, ST_READ} mac_state_e;

  localparam int NUM_OPS = 4;
  localparam int OPB_MUL = 0;
  localparam int OPB_SUB = 1;
  localparam int OPB_ADD = 2;
  localparam int OPB_DIV = 3;

  localparam int CTL_W = 8;
  localparam logic [CTL_W-1:0] CTL_READ  = 8'h10;
  localparam logic [CTL_W-1:0] CTL_CLEAR = 8'h20;

  localparam int REG_CTL = 0;
  localparam int REG_X   = 1;
  localparam int REG_Y   = 2;
  localparam int REG_M   = 3;
  localparam int REG_Z   = 4;
endpackage

// File: rtl/modarith_addsub.sv
module modarith_addsub #(
  parameter int OPW    = 160,
  parameter bit DO_SUB = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [OPW-1:0] a,
  input  logic [OPW-1:0] b,
  input  logic [OPW-1:0] m,
  output logic           done,
  output logic [OPW-1:0] res
);
  logic [OPW-1:0] nxt;

  generate
    if (DO_SUB) begin : g_sub
      logic [OPW:0] diff;
      always_comb begin
        diff = {1'b0, a} - {1'b0, b};
        nxt  = diff[OPW] ? (diff[OPW-1:0] + m) : diff[OPW-1:0];
      end
    end else begin : g_add
      logic [OPW:0] sum;
      logic [OPW:0] red;
      always_comb begin
        sum = {1'b0, a} + {1'b0, b};
        red = sum - {1'b0, m};
        nxt = (sum >= {1'b0, m}) ? red[OPW-1:0] : sum[OPW-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      res  <= '0;
    end else begin
      done <= start;
      if (start) res <= nxt;
    end
  end
endmodule

// File: rtl/modarith_mul.sv
module modarith_mul #(
  parameter int OPW = 160
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [OPW-1:0] a,
  input  logic [OPW-1:0] b,
  input  logic [OPW-1:0] m,
  output logic           done,
  output logic [OPW-1:0] res
);
  logic [OPW-1:0] acc_q, mcand_q, mplier_q, mod_q;
  logic           run_q;
  logic [OPW:0]   acc_sum, acc_red, dbl, dbl_red;
  logic [OPW-1:0] acc_nx, mcand_nx;

  always_comb begin
    acc_sum  = {1'b0, acc_q} + (mplier_q[0] ? {1'b0, mcand_q} : '0);
    acc_red  = acc_sum - {1'b0, mod_q};
    acc_nx   = (acc_sum >= {1'b0, mod_q}) ? acc_red[OPW-1:0] : acc_sum[OPW-1:0];
    dbl      = {mcand_q, 1'b0};
    dbl_red  = dbl - {1'b0, mod_q};
    mcand_nx = (dbl >= {1'b0, mod_q}) ? dbl_red[OPW-1:0] : dbl[OPW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      mod_q    <= '0;
      run_q    <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        acc_q    <= '0;
        mcand_q  <= a;
        mplier_q <= b;
        mod_q    <= m;
        run_q    <= 1'b1;
      end else if (run_q) begin
        if (mplier_q == '0) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end else begin
          acc_q    <= acc_nx;
          mcand_q  <= mcand_nx;
          mplier_q <= mplier_q >> 1;
        end
      end
    end
  end

  assign res = acc_q;
endmodule

// File: rtl/modarith_ctl.sv
module modarith_ctl
  import modarith_pkg::*;
#(
  parameter int OPW = 160
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ctl_wr,
  input  logic [CTL_W-1:0]              ctl_data,
  input  logic [NUM_OPS-1:0]            unit_done,
  input  logic [NUM_OPS-1:0][OPW-1:0]   unit_res,
  output mac_state_e                    st,
  output logic [NUM_OPS-1:0]            op_q,
  output logic [NUM_OPS-1:0]            start_v,
  output logic                          err_q,
  output logic [OPW-1:0]                z_q
);
  logic [NUM_OPS-1:0] req_op;
  logic               req_ok;
  logic [OPW-1:0]     sel_res;
  logic               sel_done;
  logic [CTL_W-1:0]   read_code;

  assign req_op    = ctl_data[NUM_OPS-1:0];
  assign req_ok    = $onehot(req_op) && (ctl_data[CTL_W-1:NUM_OPS] == '0);
  assign read_code = {{(CTL_W-NUM_OPS){1'b0}}, op_q} | CTL_READ;
  assign sel_done  = |(unit_done & op_q);

  always_comb begin
    sel_res = '0;
    for (int i = 0; i < NUM_OPS; i++) begin
      if (op_q[i]) sel_res = sel_res | unit_res[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      op_q    <= '0;
      start_v <= '0;
      err_q   <= 1'b0;
      z_q     <= '0;
    end else begin
      start_v <= '0;
      case (st)
        ST_IDLE: begin
          if (ctl_wr && req_ok) begin
            op_q <= req_op;
            z_q  <= '0;
            if (req_op[OPB_DIV]) begin
              err_q <= 1'b1;
              st    <= ST_DONE;
            end else begin
              start_v <= req_op;
              st      <= ST_BUSY;
            end
          end
        end
        ST_BUSY: begin
          if (sel_done) begin
            z_q <= sel_res;
            st  <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (ctl_wr && ctl_data == read_code) begin
            st <= ST_READ;
          end else if (ctl_wr && ctl_data == CTL_CLEAR) begin
            st    <= ST_IDLE;
            op_q  <= '0;
            err_q <= 1'b0;
            z_q   <= '0;
          end
        end
        default: begin
          if (ctl_wr && ctl_data == CTL_CLEAR) begin
            st    <= ST_IDLE;
            op_q  <= '0;
            err_q <= 1'b0;
            z_q   <= '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/modarith_cop.sv
module modarith_cop
  import modarith_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int OPW    = 160,
  parameter int ADDR_W = $clog2(OPW / WORD_W) + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata
);
  localparam int NWORDS = OPW / WORD_W;
  localparam int IDX_W  = $clog2(NWORDS);

  logic [ADDR_W-IDX_W-1:0]          region;
  logic [IDX_W-1:0]                 idx;
  logic                             idx_ok;
  logic [OPW-1:0]                   x_q, y_q, m_q, z_q;
  logic                             ctl_wr;
  mac_state_e                       st;
  logic [NUM_OPS-1:0]               op_q, start_v, unit_done;
  logic [NUM_OPS-1:0][OPW-1:0]      unit_res;
  logic                             err_q;
  logic [CTL_W-1:0]                 ctl_rb;
  logic [WORD_W-1:0]                status_w;

  assign region = bus_addr[ADDR_W-1:IDX_W];
  assign idx    = bus_addr[IDX_W-1:0];
  assign idx_ok = int'(idx) < NWORDS;
  assign ctl_wr = bus_wr && int'(region) == REG_CTL && idx == '0 &&
                  bus_wdata[WORD_W-1:CTL_W] == '0;

  // operand register file, writable only while idle
  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      y_q <= '0;
      m_q <= '0;
    end else if (bus_wr && idx_ok && st == ST_IDLE) begin
      case (int'(region))
        REG_X:   x_q[int'(idx)*WORD_W +: WORD_W] <= bus_wdata;
        REG_Y:   y_q[int'(idx)*WORD_W +: WORD_W] <= bus_wdata;
        REG_M:   m_q[int'(idx)*WORD_W +: WORD_W] <= bus_wdata;
        default: ;
      endcase
    end
  end

  modarith_ctl #(.OPW(OPW)) u_ctl (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_data(bus_wdata[CTL_W-1:0]),
    .unit_done(unit_done), .unit_res(unit_res), .st(st), .op_q(op_q),
    .start_v(start_v), .err_q(err_q), .z_q(z_q)
  );

  generate
    for (genvar i = 0; i < NUM_OPS; i++) begin : g_unit
      if (i == OPB_MUL) begin : g_mul
        modarith_mul #(.OPW(OPW)) u_mul (
          .clk(clk), .rst(rst), .start(start_v[i]), .a(x_q), .b(y_q), .m(m_q),
          .done(unit_done[i]), .res(unit_res[i])
        );
      end else if (i == OPB_SUB || i == OPB_ADD) begin : g_as
        modarith_addsub #(.OPW(OPW), .DO_SUB(i == OPB_SUB)) u_as (
          .clk(clk), .rst(rst), .start(start_v[i]), .a(x_q), .b(y_q), .m(m_q),
          .done(unit_done[i]), .res(unit_res[i])
        );
      end else begin : g_none
        assign unit_done[i] = 1'b0;
        assign unit_res[i]  = '0;
      end
    end
  endgenerate

  assign ctl_rb   = {{(CTL_W-NUM_OPS){1'b0}}, op_q} | ((st == ST_READ) ? CTL_READ : '0);
  assign status_w = {{(WORD_W-3){1'b0}}, err_q, st == ST_BUSY,
                     (st == ST_DONE || st == ST_READ)};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      case (int'(region))
        REG_CTL: begin
          if (idx == IDX_W'(0)) bus_rdata <= {{(WORD_W-CTL_W){1'b0}}, ctl_rb};
          else if (idx == IDX_W'(1)) bus_rdata <= status_w;
        end
        REG_X: if (idx_ok) bus_rdata <= x_q[int'(idx)*WORD_W +: WORD_W];
        REG_Y: if (idx_ok) bus_rdata <= y_q[int'(idx)*WORD_W +: WORD_W];
        REG_M: if (idx_ok) bus_rdata <= m_q[int'(idx)*WORD_W +: WORD_W];
        REG_Z: if (idx_ok && st == ST_READ) bus_rdata <= z_q[int'(idx)*WORD_W +: WORD_W];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/modarith_cop_chk.sv
module modarith_cop_chk
  import modarith_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int OPW    = 160,
  parameter int ADDR_W = $clog2(OPW / WORD_W) + 3
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [WORD_W-1:0]  bus_wdata,
  input logic [WORD_W-1:0]  bus_rdata,
  input mac_state_e         st,
  input logic [NUM_OPS-1:0] op_q,
  input logic [NUM_OPS-1:0] start_v,
  input logic               err_q,
  input logic [OPW-1:0]     x_q
);
  localparam int IDX_W = $clog2(OPW / WORD_W);

  logic clr_wr, z_rd;
  assign clr_wr = bus_wr && bus_addr == '0 && bus_wdata == WORD_W'(CTL_CLEAR);
  assign z_rd   = bus_rd && int'(bus_addr[ADDR_W-1:IDX_W]) == REG_Z;

  p_start_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(start_v));

  p_op_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BUSY) |=> (op_q == $past(op_q)));

  p_z_hidden_r8: assert property (@(posedge clk) disable iff (rst)
    (z_rd && st != ST_READ) |=> (bus_rdata == '0));

  p_clear_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && (st == ST_DONE || st == ST_READ)) |=> (st == ST_IDLE && !err_q));

  p_err_div_r10: assert property (@(posedge clk) disable iff (rst)
    err_q |-> op_q[OPB_DIV]);

  p_ops_locked_r11: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |=> $stable(x_q));
endmodule

bind modarith_cop modarith_cop_chk #(.WORD_W(WORD_W), .OPW(OPW), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/modarith_cop_tb.sv
module modarith_cop_tb;
  localparam int W = 32;
  localparam int N = 160;
  localparam int AW = 6;
  localparam logic [W-1:0] C_MUL = 1, C_SUB = 2, C_ADD = 4, C_DIV = 8;
  localparam logic [W-1:0] C_RD = 32'h10, C_CLR = 32'h20;
  localparam int A_CTL = 0, A_ST = 1, A_X = 8, A_Y = 16, A_M = 24, A_Z = 32;

  logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0, bus_rdata;
  int unsigned n_chk = 0, n_bad = 0;

  modarith_cop u_dut (.clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #5 clk = ~clk;

  function automatic logic [N-1:0] f_add(logic [N-1:0] x, y, m);
    logic [N:0] s = {1'b0, x} + {1'b0, y};
    if (s >= {1'b0, m}) s = s - {1'b0, m};
    return s[N-1:0];
  endfunction
  function automatic logic [N-1:0] f_sub(logic [N-1:0] x, y, m);
    return (x >= y) ? x - y : x - y + m;
  endfunction
  function automatic logic [N-1:0] f_mul(logic [N-1:0] x, y, m);
    logic [2*N-1:0] p = {{N{1'b0}}, x} * {{N{1'b0}}, y};
    p = p % {{N{1'b0}}, m};
    return p[N-1:0];
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [W-1:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [W-1:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic load(logic [N-1:0] x, y, m);
    for (int i = 0; i < 5; i++) begin
      wr(A_X + i, x[i*W +: W]); wr(A_Y + i, y[i*W +: W]); wr(A_M + i, m[i*W +: W]);
    end
  endtask

  task automatic wait_done(string tag);
    logic [W-1:0] s;
    int k = 0;
    do begin rd(A_ST, s); k++; end while (!s[0] && k < 400);
    if (!s[0]) chk({tag, " done timeout"}, s, 32'h1);
  endtask

  task automatic run_op(logic [W-1:0] code, logic [N-1:0] x, y, m, exp, string tag);
    logic [W-1:0] d;
    load(x, y, m);
    wr(A_CTL, code);
    wait_done(tag);
    rd(A_ST, d); chk({tag, " R7 status done"}, d, 32'h1);
    rd(A_Z, d);  chk({tag, " R8 z hidden before read bit"}, d, 0);
    wr(A_CTL, code | C_RD);
    for (int i = 0; i < 5; i++) begin
      rd(A_Z + i, d); chk(tag, d, exp[i*W +: W]);
    end
    wr(A_CTL, C_CLR);
    rd(A_ST, d); chk({tag, " R9 status after clear"}, d, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] d;
    logic [N-1:0] x, y, m;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(A_ST, d); chk("R1 status", d, 0);
    rd(A_X + 2, d); chk("R1 x word", d, 0);
    rd(A_Z, d); chk("R1 z word", d, 0);

    // R3 illegal control values in idle
    wr(A_CTL, 32'h3); rd(A_ST, d); chk("R3 two-bit code ignored", d, 0);
    wr(A_CTL, C_RD); rd(A_ST, d); chk("R3 read bit alone ignored", d, 0);
    wr(A_CTL, 32'h101); rd(A_ST, d); chk("R3 upper bits ignored", d, 0);

    // R2 operand map and unused indices
    x = {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111, 32'h0000000a};
    load(x, 160'd5, {1'b1, 159'd0});
    wr(A_X + 5, 32'hdeadbeef);
    rd(A_X, d); chk("R2 x lsw", d, 32'h0000000a);
    rd(A_X + 4, d); chk("R2 x msw", d, 32'h44444444);
    rd(A_X + 5, d); chk("R2 unused index", d, 0);
    rd(A_M + 4, d); chk("R2 m msw", d, 32'h80000000);

    // directed corners R4 R5 R6
    run_op(C_ADD, 160'd12, 160'd12, 160'd13, 160'd11, "R4 add wrap");
    run_op(C_ADD, 160'd0, 160'd0, 160'd13, 160'd0, "R4 add zero");
    run_op(C_SUB, 160'd3, 160'd5, 160'd13, 160'd11, "R5 sub negative");
    run_op(C_SUB, 160'd9, 160'd9, 160'd13, 160'd0, "R5 sub equal");
    run_op(C_MUL, 160'd7, 160'd0, 160'd13, 160'd0, "R6 mul by zero");
    run_op(C_MUL, 160'd12, 160'd12, 160'd13, 160'd1, "R6 mul m-1 squared");

    // R7 busy, control ignored; R11 operand lock; R8 wrong read code
    m = {1'b1, 127'd0, $urandom()} | 160'd1;
    x = m - 160'd2; y = m - 160'd3;
    load(x, y, m);
    wr(A_CTL, C_MUL);
    rd(A_ST, d); chk("R7 busy bit", d, 32'h2);
    wr(A_CTL, C_ADD); wr(A_CTL, C_CLR);
    wr(A_X, 32'h12345678);
    wait_done("R7");
    rd(A_CTL, d); chk("R7 opcode kept", d, C_MUL);
    wr(A_CTL, C_ADD | C_RD);
    rd(A_Z, d); chk("R8 wrong read code", d, 0);
    wr(A_CTL, C_MUL | C_RD);
    for (int i = 0; i < 5; i++) begin
      rd(A_Z + i, d); chk("R7 R6 result after ignored writes", d, f_mul(x, y, m)[i*W +: W]);
    end
    wr(A_CTL, C_CLR);
    rd(A_X, d); chk("R11 operand write while busy ignored", d, x[W-1:0]);

    // R9 clear straight from done
    wr(A_CTL, C_ADD); wait_done("R9");
    wr(A_CTL, C_CLR);
    rd(A_ST, d); chk("R9 clear from done", d, 0);

    // R10 division
    wr(A_CTL, C_DIV);
    rd(A_ST, d); chk("R10 done and error", d, 32'h5);
    wr(A_CTL, C_DIV | C_RD);
    rd(A_Z, d); chk("R10 z zero", d, 0);
    rd(A_Z + 4, d); chk("R10 z msw zero", d, 0);
    wr(A_CTL, C_CLR);
    rd(A_ST, d); chk("R10 flags cleared", d, 0);

    // random vectors
    for (int t = 0; t < 18; t++) begin
      m = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
      m[N-1] = 1'b1; m[0] = 1'b1;
      x = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()} % m;
      y = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()} % m;
      case (t % 3)
        0: run_op(C_ADD, x, y, m, f_add(x, y, m), "R4 random add");
        1: run_op(C_SUB, x, y, m, f_sub(x, y, m), "R5 random sub");
        default: run_op(C_MUL, x, y, m, f_mul(x, y, m), "R6 random mul");
      endcase
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule